// File: doc/BRIEF.md
# Banked DRAM Command Responder

This block sits on the device side of a test environment and stands in for a small banked DRAM. Each clock cycle it may receive one request: open a row, read a column, write a column, or close a bank. Every bank has one open-row buffer. Opening a row copies that row out of a register-based storage array into the buffer. Column reads and writes act on the buffer. Closing the bank copies the buffer back into the row it came from.

Write data is not sent with the write request. It arrives on a separate data input a fixed number of cycles after the request. Read data leaves on a separate output a fixed, longer number of cycles after the request. Reads and writes can be in flight at the same time, each in its own delay pipeline.

Alongside the data function, the block watches request spacing on a per-bank basis. A request that breaks a spacing rule raises a sticky timing flag but is still carried out, so a controller under test can be caught without the model stalling. A request that makes no sense for the bank state raises a sticky protocol flag and is dropped.

Top module: `bank_responder`

## Requirements
- R1: After reset all banks are closed, `rdValid`, `protoErr` and `timingErr` are low, and every storage location reads back as zero.
- R2: Opcode 0 (open) copies row `reqRow` of bank `reqBank` into that bank's buffer. Opcode 3 (close) uses only the bank field: it writes the buffer back to the row that was opened and closes the bank. Data therefore survives a close and a later reopen.
- R3: A write (opcode 2) accepted in cycle k stores the value on `wrData` in cycle k+3 into column `reqCol` of that bank's open row.
- R4: A read (opcode 1) accepted in cycle k raises `rdValid` for exactly one cycle, in cycle k+6, with the column's value on `rdData`. `rdValid` is never high without such a read.
- R5: If a read's capture falls in the same cycle as a write's data commit to the same bank and column (read issued three cycles after the write), the read returns the new write data. A read issued two cycles after the write returns the old value.
- R6: Reads and writes may be in flight together across banks in consecutive cycles; every read returns the correct data.
- R7: A read or write to a closed bank, or an open to an already open bank, sets the sticky `protoErr` and has no other effect. A close to a closed bank has no effect and sets no flag.
- R8: Two column commands to the same bank less than 2 cycles apart set the sticky `timingErr`. Column commands to different banks in consecutive cycles are legal. A violating command is still executed.
- R9: A read less than 5 cycles after the open of its bank sets `timingErr`. A write 1 cycle after the open is legal.
- R10: A close less than 11 cycles after the last write, or less than 3 cycles after the last read, to that bank sets `timingErr`. A close at exactly those distances does not.
- R11: `protoErr` and `timingErr` stay high until reset once set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is present this cycle |
| reqCmd | input | 2 | Opcode: 0 open, 1 read, 2 write, 3 close |
| reqBank | input | BANK_W | Bank address |
| reqRow | input | ROW_W | Row address (used by open only) |
| reqCol | input | COL_W | Column address (used by read and write) |
| wrData | input | DATA_W | Write data, sampled three cycles after a write request |
| rdData | output | DATA_W | Read data, valid with rdValid |
| rdValid | output | 1 | Read data is present this cycle |
| protoErr | output | 1 | Sticky flag for a request illegal for the bank state |
| timingErr | output | 1 | Sticky flag for a spacing-rule violation |

## Verification
A read request captures its column in the same cycle that an earlier write's delayed data lands in that column. The bench provokes this by issuing a write and then a read to the same column exactly three cycles later; the read must deliver the new data. A second case issues the read two cycles after the write, and that read must deliver the old data, which fixes the bypass boundary to a single cycle. The same cycle overlap is also exercised in bulk: reads to one bank interleave with writes to the other on every cycle, and each returned value is compared with a value the bench computes arithmetically.

// File: rtl/br_pkg.sv
package br_pkg;
  typedef enum logic [1:0] {
    CMD_OPEN  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2,
    CMD_CLOSE = 2'd3
  } cmd_e;

  // widest address field carried between control and datapath
  localparam int FIELD_W = 4;

  typedef struct packed {
    logic               loadRow;
    logic               storeRow;
    logic               rdIssue;
    logic               wrIssue;
    logic [FIELD_W-1:0] bank;
    logic [FIELD_W-1:0] row;
    logic [FIELD_W-1:0] col;
  } strobe_t;
endpackage

// File: rtl/br_ctrl.sv
module br_ctrl
  import br_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int NUM_ROWS  = 4,
  parameter int NUM_COLS  = 4,
  parameter int T_CC      = 2,
  parameter int T_RCD_WR  = 1,
  parameter int T_RCD_RD  = 5,
  parameter int T_WR_CLS  = 11,
  parameter int T_RD_CLS  = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  input  logic [1:0]                  reqCmd,
  input  logic [$clog2(NUM_BANKS)-1:0] reqBank,
  input  logic [$clog2(NUM_ROWS)-1:0]  reqRow,
  input  logic [$clog2(NUM_COLS)-1:0]  reqCol,
  output strobe_t                     strb,
  output logic                        protoErr,
  output logic                        timingErr
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int ROW_W  = $clog2(NUM_ROWS);
  localparam int FW     = FIELD_W;
  localparam int LIM_A  = (T_WR_CLS > T_RCD_RD) ? T_WR_CLS : T_RCD_RD;
  localparam int LIM_B  = (T_CC > T_RD_CLS) ? T_CC : T_RD_CLS;
  localparam int LIM_C  = (LIM_A > LIM_B) ? LIM_A : LIM_B;
  localparam int MAX_LIM = (LIM_C > T_RCD_WR) ? LIM_C : T_RCD_WR;
  localparam int CNT_W  = $clog2(MAX_LIM + 1);

  logic             bankOpen [NUM_BANKS];
  logic [ROW_W-1:0] openRow  [NUM_BANKS];
  logic [CNT_W-1:0] sinceOpen[NUM_BANKS];
  logic [CNT_W-1:0] sinceCol [NUM_BANKS];
  logic [CNT_W-1:0] sinceWr  [NUM_BANKS];
  logic [CNT_W-1:0] sinceRd  [NUM_BANKS];

  logic isOpen, isRead, isWrite, isClose, curOpen, illegal, accept, spacingBad;

  always_comb begin
    isOpen  = reqValid && (reqCmd == CMD_OPEN);
    isRead  = reqValid && (reqCmd == CMD_READ);
    isWrite = reqValid && (reqCmd == CMD_WRITE);
    isClose = reqValid && (reqCmd == CMD_CLOSE);
    curOpen = bankOpen[reqBank];
    illegal = (isOpen && curOpen) || ((isRead || isWrite) && !curOpen);
    accept  = reqValid && !illegal && !(isClose && !curOpen);
    spacingBad = 1'b0;
    if (accept && isRead)
      spacingBad = (int'(sinceOpen[reqBank]) < T_RCD_RD) || (int'(sinceCol[reqBank]) < T_CC);
    if (accept && isWrite)
      spacingBad = (int'(sinceOpen[reqBank]) < T_RCD_WR) || (int'(sinceCol[reqBank]) < T_CC);
    if (accept && isClose)
      spacingBad = (int'(sinceWr[reqBank]) < T_WR_CLS) || (int'(sinceRd[reqBank]) < T_RD_CLS);

    strb.loadRow  = accept && isOpen;
    strb.storeRow = accept && isClose;
    strb.rdIssue  = accept && isRead;
    strb.wrIssue  = accept && isWrite;
    strb.bank     = FW'(reqBank);
    strb.row      = isClose ? FW'(openRow[reqBank]) : FW'(reqRow);
    strb.col      = FW'(reqCol);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      protoErr  <= 1'b0;
      timingErr <= 1'b0;
      for (int b = 0; b < NUM_BANKS; b++) begin
        bankOpen[b]  <= 1'b0;
        openRow[b]   <= '0;
        sinceOpen[b] <= '1;
        sinceCol[b]  <= '1;
        sinceWr[b]   <= '1;
        sinceRd[b]   <= '1;
      end
    end else begin
      if (illegal)    protoErr  <= 1'b1;
      if (spacingBad) timingErr <= 1'b1;
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (sinceOpen[b] != '1) sinceOpen[b] <= sinceOpen[b] + 1'b1;
        if (sinceCol[b]  != '1) sinceCol[b]  <= sinceCol[b] + 1'b1;
        if (sinceWr[b]   != '1) sinceWr[b]   <= sinceWr[b] + 1'b1;
        if (sinceRd[b]   != '1) sinceRd[b]   <= sinceRd[b] + 1'b1;
        if (accept && (int'(reqBank) == b)) begin
          if (isOpen) begin
            bankOpen[b]  <= 1'b1;
            openRow[b]   <= reqRow;
            sinceOpen[b] <= CNT_W'(1);
            sinceCol[b]  <= '1;
            sinceWr[b]   <= '1;
            sinceRd[b]   <= '1;
          end
          if (isClose) bankOpen[b] <= 1'b0;
          if (isRead) begin
            sinceCol[b] <= CNT_W'(1);
            sinceRd[b]  <= CNT_W'(1);
          end
          if (isWrite) begin
            sinceCol[b] <= CNT_W'(1);
            sinceWr[b]  <= CNT_W'(1);
          end
        end
      end
    end
  end

  // R11
  proto_sticky_chk: assert property (@(posedge clk) disable iff (!rstN) protoErr |=> protoErr);
  // R11
  timing_sticky_chk: assert property (@(posedge clk) disable iff (!rstN) timingErr |=> timingErr);
  // R7
  illegal_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (reqCmd != CMD_CLOSE) && ((reqCmd == CMD_OPEN) == bankOpen[reqBank])) |=> protoErr);

  logic unusedBits;
  assign unusedBits = ^BANK_W;
endmodule

// File: rtl/br_data.sv
module br_data
  import br_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int NUM_ROWS  = 4,
  parameter int NUM_COLS  = 4,
  parameter int DATA_W    = 8,
  parameter int WR_LAT    = 3,
  parameter int RD_LAT    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int ROW_W  = $clog2(NUM_ROWS);
  localparam int COL_W  = $clog2(NUM_COLS);
  localparam int IF_W   = $clog2(RD_LAT + 2);

  logic [DATA_W-1:0] rowMem [NUM_BANKS][NUM_ROWS][NUM_COLS];
  logic [DATA_W-1:0] sense  [NUM_BANKS][NUM_COLS];

  logic              wpV    [WR_LAT];
  logic [BANK_W-1:0] wpBank [WR_LAT];
  logic [COL_W-1:0]  wpCol  [WR_LAT];
  logic              rpV    [RD_LAT];
  logic [DATA_W-1:0] rpD    [RD_LAT];

  logic [BANK_W-1:0] bIdx, cBank;
  logic [ROW_W-1:0]  rIdx;
  logic [COL_W-1:0]  colIdx, cCol;
  logic              commit;
  logic [DATA_W-1:0] rdNow;

  always_comb begin
    bIdx   = strb.bank[BANK_W-1:0];
    rIdx   = strb.row[ROW_W-1:0];
    colIdx = strb.col[COL_W-1:0];
    commit = wpV[WR_LAT-1];
    cBank  = wpBank[WR_LAT-1];
    cCol   = wpCol[WR_LAT-1];
    // a write landing this very cycle on the same column is forwarded
    rdNow  = (commit && cBank == bIdx && cCol == colIdx) ? wrData : sense[bIdx][colIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < NUM_BANKS; b++)
        for (int c = 0; c < NUM_COLS; c++) begin
          sense[b][c] <= '0;
          for (int r = 0; r < NUM_ROWS; r++) rowMem[b][r][c] <= '0;
        end
      for (int i = 0; i < WR_LAT; i++) begin
        wpV[i] <= 1'b0; wpBank[i] <= '0; wpCol[i] <= '0;
      end
      for (int i = 0; i < RD_LAT; i++) begin
        rpV[i] <= 1'b0; rpD[i] <= '0;
      end
    end else begin
      wpV[0] <= strb.wrIssue; wpBank[0] <= bIdx; wpCol[0] <= colIdx;
      for (int i = 1; i < WR_LAT; i++) begin
        wpV[i] <= wpV[i-1]; wpBank[i] <= wpBank[i-1]; wpCol[i] <= wpCol[i-1];
      end
      rpV[0] <= strb.rdIssue; rpD[0] <= rdNow;
      for (int i = 1; i < RD_LAT; i++) begin
        rpV[i] <= rpV[i-1]; rpD[i] <= rpD[i-1];
      end
      if (commit) sense[cBank][cCol] <= wrData;
      if (strb.loadRow)
        for (int c = 0; c < NUM_COLS; c++) sense[bIdx][c] <= rowMem[bIdx][rIdx][c];
      if (strb.storeRow)
        for (int c = 0; c < NUM_COLS; c++) rowMem[bIdx][rIdx][c] <= sense[bIdx][c];
    end
  end

  assign rdData  = rpD[RD_LAT-1];
  assign rdValid = rpV[RD_LAT-1];

  // reads in flight, kept for the checks below
  logic [IF_W-1:0] inFlight;
  always_ff @(posedge clk) begin
    if (!rstN) inFlight <= '0;
    else if (strb.rdIssue && !rdValid) inFlight <= inFlight + 1'b1;
    else if (!strb.rdIssue && rdValid) inFlight <= inFlight - 1'b1;
  end

  // R4
  rd_orphan_chk: assert property (@(posedge clk) disable iff (!rstN) rdValid |-> (inFlight != '0));
  // R6
  inflight_bound_chk: assert property (@(posedge clk) disable iff (!rstN) int'(inFlight) <= RD_LAT);
endmodule

// File: rtl/bank_responder.sv
module bank_responder
  import br_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int NUM_ROWS  = 4,
  parameter int NUM_COLS  = 4,
  parameter int DATA_W    = 8,
  parameter int WR_LAT    = 3,
  parameter int RD_LAT    = 6,
  parameter int T_CC      = 2,
  parameter int T_RCD_WR  = 1,
  parameter int T_RCD_RD  = 5,
  parameter int T_WR_CLS  = 11,
  parameter int T_RD_CLS  = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         reqValid,
  input  logic [1:0]                   reqCmd,
  input  logic [$clog2(NUM_BANKS)-1:0] reqBank,
  input  logic [$clog2(NUM_ROWS)-1:0]  reqRow,
  input  logic [$clog2(NUM_COLS)-1:0]  reqCol,
  input  logic [DATA_W-1:0]            wrData,
  output logic [DATA_W-1:0]            rdData,
  output logic                         rdValid,
  output logic                         protoErr,
  output logic                         timingErr
);
  strobe_t strb;

  br_ctrl #(
    .NUM_BANKS(NUM_BANKS), .NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS),
    .T_CC(T_CC), .T_RCD_WR(T_RCD_WR), .T_RCD_RD(T_RCD_RD),
    .T_WR_CLS(T_WR_CLS), .T_RD_CLS(T_RD_CLS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCmd(reqCmd),
    .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol),
    .strb(strb), .protoErr(protoErr), .timingErr(timingErr)
  );

  br_data #(
    .NUM_BANKS(NUM_BANKS), .NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS),
    .DATA_W(DATA_W), .WR_LAT(WR_LAT), .RD_LAT(RD_LAT)
  ) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: tb/bank_responder_bench.sv
module bank_responder_bench;
  localparam int NB = 2, NR = 4, NC = 4, DW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [1:0]    reqCmd = 2'd0;
  logic [0:0]    reqBank = 1'b0;
  logic [1:0]    reqRow = 2'd0;
  logic [1:0]    reqCol = 2'd0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic          rdValid, protoErr, timingErr;

  bank_responder u_bank_responder (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCmd(reqCmd),
    .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid), .protoErr(protoErr), .timingErr(timingErr)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  int nChk = 0, nFail = 0;
  string curTag = "R1";
  logic [DW-1:0] wrPlan [0:255];
  logic          wrPlanV[0:255];
  logic          expV   [0:255];
  logic [DW-1:0] expD   [0:255];
  logic [DW-1:0] refMem [0:31];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [4:0] ix(int b, int r, int c);
    return 5'(b * 16 + r * 4 + c);
  endfunction

  function automatic logic [DW-1:0] pat(int b, int r, int c, int p);
    return DW'((b * 16 + r * 4 + c) * 5 + p * 37 + 3);
  endfunction

  task automatic check(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // write data driver and read monitor, both away from the rising edge
  always @(negedge clk) begin
    wrData = wrPlanV[8'(cyc)] ? wrPlan[8'(cyc)] : '0;
    wrPlanV[8'(cyc)] = 1'b0;
    if (rdValid || expV[8'(cyc)]) begin
      nChk++;
      if (rdValid !== expV[8'(cyc)] || (expV[8'(cyc)] && rdData !== expD[8'(cyc)])) begin
        nFail++;
        $display("FAIL %s/R4: read actual valid=%0b data=%0h expected valid=%0b data=%0h (cycle %0d)",
                 curTag, rdValid, rdData, expV[8'(cyc)], expD[8'(cyc)], cyc);
      end
      expV[8'(cyc)] = 1'b0;
    end
  end

  task automatic tick(bit v, int c, int b, int r, int col);
    reqValid = v; reqCmd = 2'(c); reqBank = 1'(b); reqRow = 2'(r); reqCol = 2'(col);
    @(negedge clk);
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0);
  endtask
  task automatic openRow(int b, int r);  tick(1, 0, b, r, 0); endtask
  task automatic closeBank(int b);       tick(1, 3, b, 0, 0); endtask
  task automatic wr(int b, int c, logic [DW-1:0] d);
    wrPlan[8'(cyc + 3)] = d; wrPlanV[8'(cyc + 3)] = 1'b1;
    tick(1, 2, b, 0, c);
  endtask
  task automatic rd(int b, int c, logic [DW-1:0] d, bit expectData);
    if (expectData) begin expD[8'(cyc + 6)] = d; expV[8'(cyc + 6)] = 1'b1; end
    tick(1, 1, b, 0, c);
  endtask
  task automatic doReset();
    reqValid = 1'b0; rstN = 1'b0;
    idle(2);
    rstN = 1'b1;
    for (int i = 0; i < 32; i++) refMem[i] = '0;
  endtask

  task automatic sweepRead(string tag);
    curTag = tag;
    for (int r = 0; r < NR; r++) begin
      openRow(0, r); openRow(1, r); idle(3);
      for (int c = 0; c < NC; c++) begin
        rd(0, c, refMem[ix(0, r, c)], 1);
        rd(1, c, refMem[ix(1, r, c)], 1);
      end
      idle(3); closeBank(0); closeBank(1);
    end
  endtask

  task automatic sweepWrite(int p);
    for (int r = 0; r < NR; r++) begin
      openRow(0, r); openRow(1, r);
      for (int c = 0; c < NC; c++)
        for (int b = 0; b < NB; b++) begin
          wr(b, c, pat(b, r, c, p));
          refMem[ix(b, r, c)] = pat(b, r, c, p);
        end
      idle(11); closeBank(0); closeBank(1);
    end
  endtask

  // rule: 0 col-col write, 1 col-col read, 2 open-read, 3 write-close, 4 read-close, 5 open-write
  task automatic runGap(int rule, int g, string tag, bit expErr);
    doReset();
    curTag = tag;
    openRow(0, 0);
    case (rule)
      0: begin wr(0, 0, 8'h11); idle(g - 1); wr(0, 1, 8'h5A); idle(5); rd(0, 1, 8'h5A, 1); end
      1: begin idle(4); rd(0, 0, 8'h00, 1); idle(g - 1); rd(0, 1, 8'h00, 1); end
      2: begin idle(g - 1); rd(0, 0, 8'h00, 1); end
      3: begin wr(0, 0, 8'h01); idle(g - 1); closeBank(0); end
      4: begin idle(4); rd(0, 0, 8'h00, 1); idle(g - 1); closeBank(0); end
      default: begin wr(0, 2, 8'h33); end
    endcase
    idle(10);
    check(tag, int'(timingErr), int'(expErr));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      wrPlanV[i] = 1'b0; wrPlan[i] = '0; expV[i] = 1'b0; expD[i] = '0;
    end
    @(negedge clk);
    doReset();
    // R1 reset state
    check("R1", int'(rdValid), 0);
    check("R1", int'(protoErr), 0);
    check("R1", int'(timingErr), 0);
    sweepRead("R1");
    // R3, R2: write every location in both banks, read it back, overwrite, read again
    sweepWrite(1);
    sweepRead("R2/R3");
    sweepWrite(2);
    sweepRead("R2/R3");
    idle(4);
    check("R8", int'(timingErr), 0);
    check("R7", int'(protoErr), 0);

    // R6: reads of bank 0 interleaved with writes of bank 1 every cycle
    curTag = "R6";
    openRow(0, 0); openRow(1, 0); idle(4);
    for (int c = 0; c < NC; c++) begin
      rd(0, c, refMem[ix(0, 0, c)], 1);
      wr(1, c, pat(1, 0, c, 9));
      refMem[ix(1, 0, c)] = pat(1, 0, c, 9);
    end
    idle(6);
    // R5: read lands together with the write commit -> new data
    curTag = "R5";
    wr(1, 0, 8'hC3); idle(2); rd(1, 0, 8'hC3, 1);
    refMem[ix(1, 0, 0)] = 8'hC3;
    idle(4);
    // R5: read one cycle ahead of the commit -> old data
    wr(1, 1, 8'h3C); idle(1); rd(1, 1, refMem[ix(1, 0, 1)], 1);
    refMem[ix(1, 0, 1)] = 8'h3C;
    idle(12);
    closeBank(0); closeBank(1);
    idle(2);
    sweepRead("R6");
    check("R5", int'(timingErr), 0);

    // R7: protocol misuse
    curTag = "R7";
    closeBank(0); idle(2);
    check("R7", int'(protoErr), 0);
    rd(1, 2, 8'h00, 0);            // bank 1 closed: no read data may appear
    wr(0, 3, 8'hEE);               // bank 0 closed: dropped
    idle(8);
    check("R7", int'(protoErr), 1);
    openRow(0, 0); openRow(0, 1);  // second open ignored, row 0 stays loaded
    idle(5);
    rd(0, 3, refMem[ix(0, 0, 3)], 1);
    idle(8); closeBank(0);
    idle(20);
    check("R11", int'(protoErr), 1);
    doReset();
    check("R1", int'(protoErr), 0);
    curTag = "R1";
    openRow(0, 2); idle(5); rd(0, 1, 8'h00, 1); idle(8); closeBank(0); idle(2);

    // spacing rules, each at one below, at, and one above its limit
    for (int g = 1; g <= 3; g++) runGap(0, g, "R8", g < 2);
    for (int g = 1; g <= 3; g++) runGap(1, g, "R8", g < 2);
    for (int g = 4; g <= 6; g++) runGap(2, g, "R9", g < 5);
    runGap(5, 1, "R9", 1'b0);
    for (int g = 10; g <= 12; g++) runGap(3, g, "R10", g < 11);
    for (int g = 2; g <= 4; g++) runGap(4, g, "R10", g < 3);
    idle(20);
    check("R11", int'(timingErr), 0);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    #1_000_000;
    nChk++; nFail++;
    $display("FAIL watchdog (R1..R11 run incomplete): actual hung expected finished");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule